// File: doc/BRIEF.md
# Serial Panel Link Receiver

This block rebuilds parallel display words from a serialized panel link. Four data lanes and one forwarded clock lane arrive as single-bit samples, one per cycle of a bit clock that runs at seven times the pixel rate. Each frame carries seven bits per lane, and a fixed shape on the clock lane marks where the frame begins.

While unaligned, the block compares the last seven clock-lane samples against that shape on every bit clock. On a match it starts a slot counter and from then on checks the clock lane only at frame ends. Each aligned frame is placed on a 28-bit output word. A regenerated pixel clock goes high on the bit clock that updates the word, so a consumer that samples on the falling edge sees stable data. This is how a sender that launches data on its rising edge is taken in with no added logic.

A valid flag rises only after two frames in a row show the correct clock shape. It falls as soon as one frame does not. A power-down input forces every output low and drops alignment.

Top module: `panel_link_rx`

## Requirements
- R1: After reset, `word_o`, `word_vld_o` and `pix_clk_o` are all 0.
- R2: For an aligned frame, output bit 7k+j equals the j-th bit received on lane k, where j = 0 is the first bit of the frame in time.
- R3: While unaligned, the block aligns when the last seven clock-lane samples, oldest first, read 1,1,0,0,0,1,1. The frame that completes the match is the first one placed on `word_o`. Data received before that is never placed on `word_o`, and `pix_clk_o` stays 0 while unaligned.
- R4: `word_vld_o` rises at the word update of the second frame in a row with the correct clock-lane shape, and not before.
- R5: When an aligned frame ends with a clock-lane shape other than 1,1,0,0,0,1,1, `word_vld_o` drops at that frame end and `word_o` keeps the last good word. Alignment is then searched again, and two more good frames are needed before `word_vld_o` rises.
- R6: While aligned, `pix_clk_o` is 1 for four bit-clock periods starting at the bit-clock edge that updates `word_o`, then 0 for three periods. `word_o` changes only when `pix_clk_o` rises.
- R7: While `pwr_dn` is 1, `word_o`, `word_vld_o` and `pix_clk_o` are 0. Alignment and received bits are cleared, so after release the block relocks as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; holds all outputs low |
| lane_in | input | 4 | One serial sample per data lane |
| clk_lane_in | input | 1 | Serial sample of the forwarded clock lane |
| word_o | output | 28 | Rebuilt parallel word |
| word_vld_o | output | 1 | Word valid after two good frames in a row |
| pix_clk_o | output | 1 | Regenerated pixel clock; its falling edge strobes the word |

## Verification
The bench uses the default parameters: four lanes, seven slots per frame, and two good frames before valid. With these values every lock, loss and relock path finishes within a few frames. This covers hunting through unaligned garbage, a clock lane stuck low that forces a relock, and a power-down in the middle of a stream, each of which takes only a handful of frames. Because the frame is seven bits long, the bench can record the duty pattern of the pixel clock slot by slot and check it against the 4-high, 3-low shape.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic {
    ALN_HUNT  = 1'b0,
    ALN_TRACK = 1'b1
  } aln_state_t;
endpackage

// File: rtl/lnk_lane_shift.sv
module lnk_lane_shift #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             din,
  output logic [SLOTS-1:0] sh_o
);
  logic [SLOTS-1:0] sh_q, sh_nxt;

  // newest sample enters at the top, so after a frame slot j sits at bit j
  always_comb begin
    sh_nxt = {din, sh_q[SLOTS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh_q <= '0;
    else if (clr) sh_q <= '0;
    else          sh_q <= sh_nxt;
  end

  assign sh_o = sh_q;
endmodule

// File: rtl/lnk_frame_align.sv
module lnk_frame_align
  import lnk_pkg::*;
#(
  parameter int             SLOTS     = 7,
  parameter logic [SLOTS-1:0] PAT     = 7'b1100011,
  parameter int             GOOD_NEED = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SLOTS-1:0] clk_sh,
  output logic             cap_en,
  output logic             stat_en,
  output logic             good_reach,
  output logic             pix_o
);
  localparam int CW       = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int GW       = $clog2(GOOD_NEED + 1);
  localparam int HI_SLOTS = (SLOTS + 1) / 2;

  aln_state_t    st_q, st_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [GW-1:0] good_q, good_nxt;
  logic          pix_q, pix_nxt;
  logic          match, frame_end;

  always_comb begin
    match     = (clk_sh == PAT);
    frame_end = (st_q == ALN_TRACK) ? (cnt_q == CW'(SLOTS - 1)) : match;
    st_nxt    = st_q;
    cnt_nxt   = cnt_q;
    good_nxt  = good_q;
    if (frame_end) begin
      cnt_nxt = '0;
      if (match) begin
        st_nxt   = ALN_TRACK;
        good_nxt = (good_q >= GW'(GOOD_NEED)) ? good_q : good_q + GW'(1);
      end else begin
        st_nxt   = ALN_HUNT;
        good_nxt = '0;
      end
    end else if (st_q == ALN_TRACK) begin
      cnt_nxt = cnt_q + CW'(1);
    end
    pix_nxt    = (st_nxt == ALN_TRACK) && (cnt_nxt < CW'(HI_SLOTS));
    cap_en     = frame_end && match;
    stat_en    = frame_end;
    good_reach = (good_nxt >= GW'(GOOD_NEED));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ALN_HUNT;
      cnt_q  <= '0;
      good_q <= '0;
      pix_q  <= 1'b0;
    end else if (clr) begin
      st_q   <= ALN_HUNT;
      cnt_q  <= '0;
      good_q <= '0;
      pix_q  <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      cnt_q  <= cnt_nxt;
      good_q <= good_nxt;
      pix_q  <= pix_nxt;
    end
  end

  assign pix_o = pix_q;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(SLOTS)); // R3

  AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ALN_HUNT && match && !clr) |=> (st_q == ALN_TRACK && cnt_q == '0 && pix_q)); // R3

  AST_HUNT_PIX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ALN_HUNT) |-> !pix_q); // R3
endmodule

// File: rtl/lnk_word_out.sv
module lnk_word_out #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cap_en,
  input  logic         stat_en,
  input  logic         good_reach,
  input  logic         pix_in,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] word_o,
  output logic         vld_o,
  output logic         pix_o
);
  logic [W-1:0] word_q, word_nxt;
  logic         vld_q, vld_nxt;

  always_comb begin
    word_nxt = cap_en  ? data_in    : word_q;
    vld_nxt  = stat_en ? good_reach : vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else if (clr) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_nxt;
      vld_q  <= vld_nxt;
    end
  end

  assign word_o = clr ? '0 : word_q;
  assign vld_o  = vld_q & ~clr;
  assign pix_o  = pix_in & ~clr;

  AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (word_q == '0 && !vld_q)); // R7

  AST_WORD_ON_PIX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(word_q) && !$past(clr)) |-> $rose(pix_in)); // R6

  AST_VALID_ON_PIX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $rose(pix_in)); // R4

  AST_LOSS_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_en && !cap_en) |=> (!vld_q && $stable(word_q))); // R5
endmodule

// File: rtl/panel_link_rx.sv
module panel_link_rx #(
  parameter int               LANES     = 4,
  parameter int               SLOTS     = 7,
  parameter logic [SLOTS-1:0] CLK_PAT   = 7'b1100011,
  parameter int               GOOD_NEED = 2
) (
  input  logic                   clk_bit,
  input  logic                   rst_n,
  input  logic                   pwr_dn,
  input  logic [LANES-1:0]       lane_in,
  input  logic                   clk_lane_in,
  output logic [LANES*SLOTS-1:0] word_o,
  output logic                   word_vld_o,
  output logic                   pix_clk_o
);
  localparam int W = LANES * SLOTS;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [W-1:0]     data_w;
  logic [SLOTS-1:0] clk_sh;
  logic             cap_en, stat_en, good_reach, pix_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lnk_lane_shift #(.SLOTS(SLOTS)) i_shift (
      .clk   (clk_bit),
      .rst_n (rst_int_n),
      .clr   (pwr_dn),
      .din   (lane_in[k]),
      .sh_o  (data_w[k*SLOTS +: SLOTS])
    );
  end

  lnk_lane_shift #(.SLOTS(SLOTS)) i_clk_shift (
    .clk   (clk_bit),
    .rst_n (rst_int_n),
    .clr   (pwr_dn),
    .din   (clk_lane_in),
    .sh_o  (clk_sh)
  );

  lnk_frame_align #(.SLOTS(SLOTS), .PAT(CLK_PAT), .GOOD_NEED(GOOD_NEED)) i_align (
    .clk        (clk_bit),
    .rst_n      (rst_int_n),
    .clr        (pwr_dn),
    .clk_sh     (clk_sh),
    .cap_en     (cap_en),
    .stat_en    (stat_en),
    .good_reach (good_reach),
    .pix_o      (pix_w)
  );

  lnk_word_out #(.W(W)) i_out (
    .clk        (clk_bit),
    .rst_n      (rst_int_n),
    .clr        (pwr_dn),
    .cap_en     (cap_en),
    .stat_en    (stat_en),
    .good_reach (good_reach),
    .pix_in     (pix_w),
    .data_in    (data_w),
    .word_o     (word_o),
    .vld_o      (word_vld_o),
    .pix_o      (pix_clk_o)
  );
endmodule

// File: tb/test_panel_link_rx.sv
module test_panel_link_rx;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] GOOD_PAT = 7'b1100011;
  localparam logic [6:0] PIX_EXP  = 7'b0011110;

  logic        clk_bit = 1'b0;
  logic        rst_n;
  logic        pwr_dn;
  logic [3:0]  lane_in;
  logic        clk_lane_in;
  logic [27:0] word_o;
  logic        word_vld_o;
  logic        pix_clk_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [27:0] last_good;
  logic [6:0]  pix_seen;

  always #(CLK_PERIOD/2) clk_bit = ~clk_bit;

  panel_link_rx i_panel_link_rx (
    .clk_bit     (clk_bit),
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .lane_in     (lane_in),
    .clk_lane_in (clk_lane_in),
    .word_o      (word_o),
    .word_vld_o  (word_vld_o),
    .pix_clk_o   (pix_clk_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [27:0] w, input logic [6:0] pat, output logic [6:0] seen);
    for (int j = 0; j < 7; j++) begin
      @(negedge clk_bit);
      seen[j] = pix_clk_o;
      for (int k = 0; k < 4; k++) lane_in[k] = w[7*k + j];
      clk_lane_in = pat[j];
    end
  endtask

  task automatic t_reset();
    @(negedge clk_bit);
    chk("R1 word", 32'(word_o), 0);
    chk("R1 valid", 32'(word_vld_o), 0);
    chk("R1 pix", 32'(pix_clk_o), 0);
  endtask

  task automatic t_lock();
    logic [6:0] s;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk_bit);
      lane_in = 4'(j * 5 + 3);
      clk_lane_in = 1'b0;
    end
    @(negedge clk_bit);
    chk("R3 no word from garbage", 32'(word_o), 0);
    chk("R3 pix low unaligned", 32'(pix_clk_o), 0);
    send_frame(28'h3C5A1E7, GOOD_PAT, s);
    chk("R3 lock frame not yet out", 32'(word_o), 0);
    send_frame(28'h0F0F0F0, GOOD_PAT, s);
    chk("R3 first aligned word", 32'(word_o), 32'h3C5A1E7);
    chk("R4 valid low after one frame", 32'(word_vld_o), 0);
    send_frame(28'h1111111, GOOD_PAT, s);
    chk("R4 valid after two frames", 32'(word_vld_o), 1);
    chk("R2 second word", 32'(word_o), 32'h0F0F0F0);
    last_good = 28'h1111111;
  endtask

  task automatic t_map();
    logic [27:0] pats [5];
    logic [6:0] s;
    pats[0] = 28'hFFFFFFF; pats[1] = 28'h0000001; pats[2] = 28'h8000000;
    pats[3] = 28'h5A3C96E; pats[4] = 28'h1234567;
    for (int i = 0; i < 5; i++) begin
      send_frame(pats[i], GOOD_PAT, s);
      chk("R2 lane mapping", 32'(word_o), 32'(last_good));
      chk("R6 pix duty", 32'(s), 32'(PIX_EXP));
      last_good = pats[i];
    end
  endtask

  task automatic t_loss();
    logic [6:0] s;
    send_frame(28'hDEADBEE, 7'b0000000, s);
    chk("R5 prior word out", 32'(word_o), 32'(last_good));
    send_frame(28'h2468ACE, GOOD_PAT, s);
    chk("R5 word held on bad frame", 32'(word_o), 32'(last_good));
    chk("R5 valid dropped", 32'(word_vld_o), 0);
    send_frame(28'h7654321, GOOD_PAT, s);
    chk("R5 relocked word", 32'(word_o), 32'h2468ACE);
    chk("R5 valid low after relock frame", 32'(word_vld_o), 0);
    send_frame(28'h0A0B0C0, GOOD_PAT, s);
    chk("R5 valid back", 32'(word_vld_o), 1);
    chk("R5 second relock word", 32'(word_o), 32'h7654321);
  endtask

  task automatic t_pwrdn();
    logic [6:0] s;
    chk("R7 precondition valid", 32'(word_vld_o), 1);
    pwr_dn = 1'b1;
    #1;
    chk("R7 word low", 32'(word_o), 0);
    chk("R7 valid low", 32'(word_vld_o), 0);
    chk("R7 pix low", 32'(pix_clk_o), 0);
    send_frame(28'h6666666, GOOD_PAT, s);
    chk("R7 pix held low", 32'(s), 0);
    chk("R7 word still low", 32'(word_o), 0);
    pwr_dn = 1'b0;
    send_frame(28'h1357BDF, GOOD_PAT, s);
    chk("R7 nothing before relock", 32'(word_o), 0);
    send_frame(28'h2222222, GOOD_PAT, s);
    chk("R7 relock word", 32'(word_o), 32'h1357BDF);
    chk("R7 valid waits", 32'(word_vld_o), 0);
    send_frame(28'h3333333, GOOD_PAT, s);
    chk("R7 valid after relock", 32'(word_vld_o), 1);
    chk("R7 word after relock", 32'(word_o), 32'h2222222);
  endtask

  initial begin
    rst_n = 1'b0;
    pwr_dn = 1'b0;
    lane_in = '0;
    clk_lane_in = 1'b0;
    repeat (3) @(negedge clk_bit);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_bit);
    t_reset();
    t_lock();
    t_map();
    t_loss();
    t_pwrdn();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_bit);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule